// File: doc/BRIEF.md
# Indexed Register File with Per-Input Operand Buffers

This block is the data-storage side of a small arithmetic datapath. It holds a 32-entry register file with one read port and one write port. On each port a mode bit chooses between two ways to find the target register. In direct mode the register number comes straight from the port's field. In indirect mode the field names a pointer register, and the low five bits of that pointer's contents pick the target. A table or small array can therefore stay in registers and be walked by a computed index, with no trip to data memory. An optional bump bit on either port advances the pointer register by one after an indirect access, so a loop can step through such an array without extra instructions.

Under the register file, each ALU input has its own four-slot operand buffer. A slot is loaded either from the register file's read data or from the ALU result that is fed back. The ALU reads the buffer combinationally, in the same cycle as its operation, through a per-input slot select. The ALU, the data cache and the instruction decode lie outside this block.

Top module: `ixrf_top`

## Requirements
- R1: After reset is released, all 32 register-file entries and all operand-buffer slots read as zero.
- R2: With `rd_ind`=0, `rd_data` shows, in the same cycle and without a clock edge, the entry whose number is `rd_sel`.
- R3: With `rd_ind`=1, `rd_data` shows the entry whose number is bits [4:0] of the entry named by `rd_sel`, so that pointer values of 32 or more wrap modulo 32.
- R4: With `wr_en`=1 and `wr_ind`=0, entry `wr_sel` holds `wr_data` after the clock edge.
- R5: With `wr_en`=1 and `wr_ind`=1, the entry selected by bits [4:0] of the entry named by `wr_sel` holds `wr_data` after the clock edge.
- R6: When a read and a write resolve to the same entry in one cycle, `rd_data` returns the old contents during that cycle and the new contents from the next cycle on.
- R7: An indirect access with its bump bit set (`rd_en`&`rd_ind`&`rd_bump` on the read port, `wr_en`&`wr_ind`&`wr_bump` on the write port) sets the pointer entry to its old value plus one, modulo 2^16, at the clock edge. In direct mode the bump bit has no effect.
- R8: If the write port writes data to a pointer entry that is also being bumped, the written data wins. If both ports bump the same pointer entry in one cycle, it advances by exactly one.
- R9: For each ALU input k, `ld_en[k]`=1 stores into slot `ld_slot[2k+1:2k]` the value of `rd_data` when `ld_src[k]`=0, or of `alu_res` when `ld_src[k]`=1.
- R10: `op_data[16k+15:16k]` shows slot `op_sel[2k+1:2k]` of input k combinationally. A slot loaded in cycle N shows its old value in cycle N and the new value from cycle N+1.
- R11: The operand buffers of the two inputs are independent: a load into one input never changes the other input's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read access valid (allows the read-port bump) |
| rd_ind | input | 1 | Read mode: 0 direct, 1 indirect |
| rd_bump | input | 1 | Bump the read pointer after an indirect read |
| rd_sel | input | 5 | Read register number or pointer register number |
| rd_data | output | 16 | Read data, combinational |
| wr_en | input | 1 | Write enable |
| wr_ind | input | 1 | Write mode: 0 direct, 1 indirect |
| wr_bump | input | 1 | Bump the write pointer after an indirect write |
| wr_sel | input | 5 | Write register number or pointer register number |
| wr_data | input | 16 | Write data |
| alu_res | input | 16 | ALU result fed back for operand-buffer loads |
| ld_en | input | 2 | Operand-buffer load enable, one bit per ALU input |
| ld_src | input | 2 | Load source per input: 0 register file, 1 ALU result |
| ld_slot | input | 4 | Slot to load, two bits per input |
| op_sel | input | 4 | Slot to read, two bits per input |
| op_data | output | 32 | Operand per ALU input, 16 bits each |

## Verification
The bench aims at pointer values of 32 and above. A design that did not wrap them would fetch the wrong entry, or nothing at all. It also runs reads and writes to the same entry in the same cycle, where a forwarding design would return the new value one cycle too early. The same holds for an operand slot that is loaded while it is being selected. Pointer bumps are exercised against a data write to the same pointer and against a double bump from both ports. A wrong priority would leave the pointer at old+1 or old+2 instead of the written value or old+1. Long random runs mix direct and indirect access on both ports, including bump bits in direct mode, which must leave every pointer untouched.

// File: rtl/ixrf_pkg.sv
package ixrf_pkg;
  parameter int unsigned DATA_W   = 16;
  parameter int unsigned XRF_N    = 32;
  parameter int unsigned OPF_N    = 4;
  parameter int unsigned ALU_INS  = 2;
  localparam int unsigned XRF_AW  = $clog2(XRF_N);
  localparam int unsigned OPF_AW  = $clog2(OPF_N);

  typedef enum logic { SRC_XRF = 1'b0, SRC_ALU = 1'b1 } opf_src_e;
endpackage

// File: rtl/ixrf_rst_sync.sv
module ixrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ixrf_regfile.sv
module ixrf_regfile #(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 32,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_ind,
  input  logic          rd_bump,
  input  logic [AW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic          wr_ind,
  input  logic          wr_bump,
  input  logic [AW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data
);
  logic [N-1:0][W-1:0] ent_q;
  logic [N-1:0][W-1:0] ent_d;
  logic [N-1:0]        ent_ce;
  logic [AW-1:0]       rd_addr;
  logic [AW-1:0]       wr_addr;
  logic [W-1:0]        rd_ptr;
  logic [W-1:0]        wr_ptr;
  logic                rd_step;
  logic                wr_step;

  // Pointer fetch: low address bits give modulo-N wrap
  always_comb begin
    rd_ptr  = ent_q[rd_sel];
    wr_ptr  = ent_q[wr_sel];
    rd_addr = rd_ind ? rd_ptr[AW-1:0] : rd_sel;
    wr_addr = wr_ind ? wr_ptr[AW-1:0] : wr_sel;
    rd_step = rd_en & rd_ind & rd_bump;
    wr_step = wr_en & wr_ind & wr_bump;
  end

  assign rd_data = ent_q[rd_addr];

  // Next state: data write overrides pointer bumps
  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      ent_d[i]  = ent_q[i];
      ent_ce[i] = 1'b0;
      if ((rd_step && rd_sel == AW'(i)) || (wr_step && wr_sel == AW'(i))) begin
        ent_d[i]  = ent_q[i] + W'(1);
        ent_ce[i] = 1'b1;
      end
      if (wr_en && wr_addr == AW'(i)) begin
        ent_d[i]  = wr_data;
        ent_ce[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (ent_ce[i]) ent_q[i] <= ent_d[i];
      end
    end
  end

  // Checker state
  logic          chk_wr_vld;
  logic [AW-1:0] chk_wr_addr;
  logic [W-1:0]  chk_wr_val;
  logic          chk_inc_vld;
  logic [AW-1:0] chk_inc_addr;
  logic [W-1:0]  chk_inc_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_wr_vld   <= 1'b0;
      chk_wr_addr  <= '0;
      chk_wr_val   <= '0;
      chk_inc_vld  <= 1'b0;
      chk_inc_addr <= '0;
      chk_inc_val  <= '0;
    end else begin
      chk_wr_vld   <= wr_en;
      chk_wr_addr  <= wr_addr;
      chk_wr_val   <= wr_data;
      chk_inc_vld  <= rd_step && !(wr_en && wr_addr == rd_sel);
      chk_inc_addr <= rd_sel;
      chk_inc_val  <= rd_ptr + W'(1);
    end
  end

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr_vld |-> ent_q[chk_wr_addr] == chk_wr_val);

  p_bump_adds_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_inc_vld |-> ent_q[chk_inc_addr] == chk_inc_val);

  p_direct_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_ind) |=> $stable(ent_q));
endmodule

// File: rtl/ixrf_opfile.sv
module ixrf_opfile #(
  parameter int unsigned W  = 16,
  parameter int unsigned D  = 4,
  parameter int unsigned SW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_src,
  input  logic [SW-1:0] ld_slot,
  input  logic [W-1:0]  xrf_data,
  input  logic [W-1:0]  alu_data,
  input  logic [SW-1:0] rd_slot,
  output logic [W-1:0]  opnd
);
  import ixrf_pkg::*;

  logic [D-1:0][W-1:0] slot_q;
  logic [D-1:0][W-1:0] slot_d;
  logic [D-1:0]        slot_ce;
  logic [W-1:0]        ld_val;

  always_comb begin
    ld_val = (opf_src_e'(ld_src) == SRC_ALU) ? alu_data : xrf_data;
    for (int s = 0; s < int'(D); s++) begin
      slot_ce[s] = ld_en && ld_slot == SW'(s);
      slot_d[s]  = slot_ce[s] ? ld_val : slot_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int s = 0; s < int'(D); s++) begin
        if (slot_ce[s]) slot_q[s] <= slot_d[s];
      end
    end
  end

  // Same-cycle read: old value while loading
  assign opnd = slot_q[rd_slot];

  logic          chk_vld;
  logic [SW-1:0] chk_slot;
  logic [W-1:0]  chk_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_slot <= '0;
      chk_val  <= '0;
    end else begin
      chk_vld  <= ld_en;
      chk_slot <= ld_slot;
      chk_val  <= ld_src ? alu_data : xrf_data;
    end
  end

  p_load_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> slot_q[chk_slot] == chk_val);

  p_hold_without_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(slot_q));
endmodule

// File: rtl/ixrf_top.sv
module ixrf_top
  import ixrf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic                          rd_ind,
  input  logic                          rd_bump,
  input  logic [XRF_AW-1:0]             rd_sel,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          wr_en,
  input  logic                          wr_ind,
  input  logic                          wr_bump,
  input  logic [XRF_AW-1:0]             wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [DATA_W-1:0]             alu_res,
  input  logic [ALU_INS-1:0]            ld_en,
  input  logic [ALU_INS-1:0]            ld_src,
  input  logic [ALU_INS*OPF_AW-1:0]     ld_slot,
  input  logic [ALU_INS*OPF_AW-1:0]     op_sel,
  output logic [ALU_INS*DATA_W-1:0]     op_data
);
  logic rst_int_n;

  ixrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ixrf_regfile #(.W(DATA_W), .N(XRF_N), .AW(XRF_AW)) u_xrf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en   (rd_en),
    .rd_ind  (rd_ind),
    .rd_bump (rd_bump),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_ind  (wr_ind),
    .wr_bump (wr_bump),
    .wr_sel  (wr_sel),
    .wr_data (wr_data)
  );

  for (genvar k = 0; k < int'(ALU_INS); k++) begin : g_opf
    ixrf_opfile #(.W(DATA_W), .D(OPF_N), .SW(OPF_AW)) u_opf (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .ld_en    (ld_en[k]),
      .ld_src   (ld_src[k]),
      .ld_slot  (ld_slot[k*OPF_AW +: OPF_AW]),
      .xrf_data (rd_data),
      .alu_data (alu_res),
      .rd_slot  (op_sel[k*OPF_AW +: OPF_AW]),
      .opnd     (op_data[k*DATA_W +: DATA_W])
    );
  end
endmodule

// File: tb/sim_ixrf_top.sv
module sim_ixrf_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rd_en, rd_ind, rd_bump;
  logic [4:0]  rd_sel;
  logic [15:0] rd_data;
  logic        wr_en, wr_ind, wr_bump;
  logic [4:0]  wr_sel;
  logic [15:0] wr_data;
  logic [15:0] alu_res;
  logic [1:0]  ld_en, ld_src;
  logic [3:0]  ld_slot, op_sel;
  logic [31:0] op_data;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    done  = 0;

  int unsigned xm [32];
  int unsigned om [2][4];

  ixrf_top u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned ex_rd();
    int unsigned a;
    a = rd_ind ? (xm[rd_sel] % 32) : rd_sel;
    return xm[a];
  endfunction

  task automatic cmp(input string what, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare mid-cycle, then advance model with the same inputs
  task automatic tick();
    int unsigned nx [32];
    int unsigned rv;
    int unsigned wa;
    #(CLK_PERIOD/2);
    rv = ex_rd();
    cmp("rd_data", rd_data, rv);
    for (int k = 0; k < 2; k++)
      cmp($sformatf("op_data[%0d]", k), op_data[k*16 +: 16], om[k][op_sel[k*2 +: 2]]);
    @(posedge clk);
    nx = xm;
    wa = wr_ind ? (xm[wr_sel] % 32) : wr_sel;
    if (rd_en && rd_ind && rd_bump) nx[rd_sel] = (xm[rd_sel] + 1) % 65536;
    if (wr_en && wr_ind && wr_bump) nx[wr_sel] = (xm[wr_sel] + 1) % 65536;
    if (wr_en) nx[wa] = wr_data;
    for (int k = 0; k < 2; k++)
      if (ld_en[k]) om[k][ld_slot[k*2 +: 2]] = ld_src[k] ? alu_res : rv;
    xm = nx;
    #1;
  endtask

  task automatic idle();
    rd_en = 0; rd_ind = 0; rd_bump = 0; rd_sel = 0;
    wr_en = 0; wr_ind = 0; wr_bump = 0; wr_sel = 0; wr_data = 0;
    alu_res = 0; ld_en = 0; ld_src = 0; ld_slot = 0; op_sel = 0;
  endtask

  task automatic wdir(input int r, input int unsigned v);
    idle(); wr_en = 1; wr_sel = 5'(r); wr_data = 16'(v); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    foreach (xm[i]) xm[i] = 0;
    foreach (om[k, s]) om[k][s] = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R1: every entry and slot is zero after reset
    tag = "R1";
    for (int r = 0; r < 32; r++) begin
      idle(); rd_en = 1; rd_sel = 5'(r); op_sel = {2'(r), 2'(r + 1)}; tick();
    end

    // R4 / R2: direct writes then direct reads
    tag = "R4";
    for (int r = 0; r < 32; r++) wdir(r, 16'h1000 + r * 7);
    tag = "R2";
    for (int r = 31; r >= 0; r--) begin
      idle(); rd_en = 1; rd_sel = 5'(r); tick();
    end

    // R3: pointer 37 wraps to entry 5, pointer 100 to entry 4
    tag = "R3";
    wdir(3, 37); wdir(5, 16'hBEEF); wdir(6, 100);
    idle(); rd_en = 1; rd_ind = 1; rd_sel = 3; tick();
    idle(); rd_en = 1; rd_ind = 1; rd_sel = 6; tick();

    // R5: indirect write through pointer 3 (->5)
    tag = "R5";
    idle(); wr_en = 1; wr_ind = 1; wr_sel = 3; wr_data = 16'h5A5A; tick();
    idle(); rd_sel = 5; tick();

    // R6: same-entry read and write in one cycle
    tag = "R6";
    idle(); rd_en = 1; rd_sel = 9; wr_en = 1; wr_sel = 9; wr_data = 16'hCAFE; tick();
    idle(); rd_sel = 9; tick();

    // R7: bump after indirect read, pointer at 0xFFFF wraps; direct bump ignored
    tag = "R7";
    wdir(10, 16'hFFFF);
    idle(); rd_en = 1; rd_ind = 1; rd_bump = 1; rd_sel = 10; tick();
    idle(); rd_sel = 10; tick();
    idle(); rd_en = 1; rd_bump = 1; rd_sel = 10; wr_en = 1; wr_bump = 1; wr_sel = 11; wr_data = 3; tick();
    idle(); rd_sel = 10; tick();
    idle(); wr_en = 1; wr_ind = 1; wr_bump = 1; wr_sel = 3; wr_data = 16'h7777; tick();
    idle(); rd_sel = 3; tick();

    // R8: double bump advances once; data write beats bump
    tag = "R8";
    wdir(12, 20);
    idle(); rd_en = 1; rd_ind = 1; rd_bump = 1; rd_sel = 12;
    wr_en = 1; wr_ind = 1; wr_bump = 1; wr_sel = 12; wr_data = 16'h0101; tick();
    idle(); rd_sel = 12; tick();
    idle(); rd_en = 1; rd_ind = 1; rd_bump = 1; rd_sel = 12;
    wr_en = 1; wr_sel = 12; wr_data = 16'h0042; tick();
    idle(); rd_sel = 12; tick();

    // R9 / R10: loads from both sources, select the slot being loaded
    tag = "R9";
    idle(); rd_sel = 5; ld_en = 2'b01; ld_src = 2'b00; ld_slot = 4'b0010; op_sel = 4'b0010; tick();
    idle(); alu_res = 16'h1234; ld_en = 2'b10; ld_src = 2'b10; ld_slot = 4'b1100; op_sel = 4'b1110; tick();
    tag = "R10";
    idle(); op_sel = 4'b1110; tick();

    // R11: load input 0 only, sweep input 1 slots
    tag = "R11";
    for (int s = 0; s < 4; s++) begin
      idle(); alu_res = 16'(16'h900 + s); ld_en = 2'b01; ld_src = 2'b01; ld_slot = 4'(s);
      op_sel = {2'(s), 2'(s)}; tick();
    end

    // Mixed traffic over every requirement
    tag = "R2-mix";
    for (int i = 0; i < 3000; i++) begin
      rd_en = 1'($urandom); rd_ind = 1'($urandom); rd_bump = 1'($urandom); rd_sel = 5'($urandom);
      wr_en = 1'($urandom); wr_ind = 1'($urandom); wr_bump = 1'($urandom); wr_sel = 5'($urandom);
      wr_data = ($urandom % 4 == 0) ? 16'($urandom % 40) : 16'($urandom);
      alu_res = 16'($urandom); ld_en = 2'($urandom); ld_src = 2'($urandom);
      ld_slot = 4'($urandom); op_sel = 4'($urandom);
      tick();
    end

    finish_run();
  end
endmodule